// File: doc/BRIEF.md
# Scripted Power Transition Sequencer

This block runs short power-transition scripts out of a small on-chip instruction memory. Each instruction carries a 16-bit resource message, a delay and the index of the next instruction. When a transition event is accepted, the sequencer starts at that transition's start pointer. For each instruction it broadcasts the message, waits out the delay and then follows the link. It stops when it reaches the reserved end index.

A host fills the instruction memory one byte at a time through an address register and a data register. It sets one start pointer for each transition: sleep entry, wake of groups 1 and 2, wake of group 3, warm reset and device off. It also sets per-group event controls. A two-key unlock protects every configuration write. Events arrive on dedicated inputs, or as a device-off request written by software. Only one script runs at a time, and the host can read the busy flag.

Top module: `pwr_seq_top`

## Requirements
- R1: Writes to every register other than the key register (offset 0x00) have no effect unless the key register has first received 0xC0 and then 0x0C.
- R2: Writing 0 to the key register relocks. Any value other than the expected key also relocks. The keys written in the wrong order leave the block locked. Status bit 1 (offset 0x0D) reads 1 only while unlocked.
- R3: After reset the following hold: all five start pointers (offsets 0x03 sleep, 0x04 wake12, 0x05 wake3, 0x06 warm, 0x07 off) read 0x3F; the shared transition byte (0x0B) reads 0x01; the group-1 transition byte (0x0C) reads 0x02; status reads 0; busy is low.
- R4: Instruction i occupies memory bytes 4i..4i+3, holding message high byte, message low byte, delay and next index. Its message appears on `msg` with `msg_valid` high for exactly one cycle. This strobe comes at the start of the instruction, before its delay.
- R5: The sequencer follows next indices until it meets 0x3F. At that point the script ends and busy falls.
- R6: Consecutive strobes within one script are 7 + d*PRESCALE cycles apart, where d is the delay byte of the earlier instruction. A delay of 0 gives 7 cycles.
- R7: An event whose start pointer is 0x3F runs nothing and leaves busy low.
- R8: Events present in the same cycle are served in this order: warm reset, device off, sleep entry, wake12, wake3. Only the winner runs.
- R9: Events that arrive while a script runs are dropped.
- R10: When bit 3 of a group's event byte (0x08, 0x09, 0x0A) is 0, a wake input triggers on its rising edge. When bit 3 is 1, the wake input triggers while it is high, so a level raised during a running script starts its wake script once the sequencer is idle.
- R11: A warm reset input runs the warm script only when bit 4 of at least one event byte is set.
- R12: Writing bit 0 = 1 to the group-1 event byte (0x08) requests the device-off script. That bit always reads back 0.
- R13: When bit 1 of the group-1 transition byte is 1, a rising edge on the charger input starts the wake12 script. When bit 1 is 0, the charger input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write value |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 8 | Read value, registered one cycle after rd_addr |
| sleep_req | input | 1 | Sleep-entry event, sampled as a level |
| wake12_in | input | 1 | Wake request for groups 1 and 2 |
| wake3_in | input | 1 | Wake request for group 3 |
| chg_in | input | 1 | Charger event |
| warm_in | input | 1 | Warm reset event |
| msg | output | 16 | Resource message of the current instruction |
| msg_valid | output | 1 | One-cycle strobe qualifying msg |
| busy | output | 1 | A script is running |

## Verification
The assertions assume that all event inputs are synchronous to the clock, and that sleep and warm requests last a single cycle. They also assume the host writes registers only through the wr_en/wr_addr/wr_data port. The stimulus drives every input on the falling edge and holds sleep and warm pulses for exactly one cycle. It raises and drops wake and charger levels only at chosen points, so every edge or level event happens in a known sequencer state. Scripts are placed at fixed indices, so all next indices stay below the end index.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hC0;
  localparam logic [7:0] KEY_SECOND = 8'h0C;

  localparam logic [7:0] A_KEY   = 8'h00;
  localparam logic [7:0] A_MADDR = 8'h01;
  localparam logic [7:0] A_MDATA = 8'h02;
  localparam logic [7:0] A_PTR0  = 8'h03;
  localparam logic [7:0] A_EV1   = 8'h08;
  localparam logic [7:0] A_EV2   = 8'h09;
  localparam logic [7:0] A_EV3   = 8'h0A;
  localparam logic [7:0] A_CFGSH = 8'h0B;
  localparam logic [7:0] A_CFG1  = 8'h0C;
  localparam logic [7:0] A_STAT  = 8'h0D;

  localparam int NPTR     = 5;
  localparam int PI_SLEEP = 0;
  localparam int PI_W12   = 1;
  localparam int PI_W3    = 2;
  localparam int PI_WARM  = 3;
  localparam int PI_OFF   = 4;

  typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lock_t;
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT, S_WAIT} eng_state_t;
endpackage

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int AW = IDX_W + 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [7:0]                        wr_addr,
  input  logic [7:0]                        wr_data,
  input  logic [7:0]                        rd_addr,
  output logic [7:0]                        rd_data,
  input  logic                              busy,
  output logic                              unlocked,
  output logic                              mem_we,
  output logic [AW-1:0]                     mem_waddr,
  output logic [7:0]                        mem_wdata,
  output logic                              off_req,
  output logic [NPTR-1:0][IDX_W-1:0]        ptr_idx,
  output logic                              lvl12,
  output logic                              lvl3,
  output logic                              warm_en,
  output logic                              chg_en
);
  localparam logic [7:0] END_BYTE = 8'((1 << IDX_W) - 1);

  lock_t                 lk;
  logic [AW-1:0]         maddr;
  logic [NPTR-1:0][7:0]  ptr;
  logic [2:0][7:0]       ev;
  logic [7:0]            cfg_sh;
  logic [7:0]            cfg_g1;

  assign unlocked = (lk == LK_OPEN);

  function automatic lock_t lock_next(lock_t cur, logic [7:0] d);
    if (d == KEY_FIRST)                     return LK_HALF;
    else if (cur == LK_HALF && d == KEY_SECOND) return LK_OPEN;
    else                                    return LK_LOCKED;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lk        <= LK_LOCKED;
      maddr     <= '0;
      ptr       <= {NPTR{END_BYTE}};
      ev        <= '0;
      cfg_sh    <= 8'h01;
      cfg_g1    <= 8'h02;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
      off_req   <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      off_req <= 1'b0;
      if (wr_en) begin
        if (wr_addr == A_KEY) begin
          lk <= lock_next(lk, wr_data);
        end else if (lk == LK_OPEN) begin
          if (wr_addr >= A_PTR0 && wr_addr < A_PTR0 + 8'(NPTR))
            ptr[3'(wr_addr - A_PTR0)] <= wr_data;
          case (wr_addr)
            A_MADDR: maddr <= wr_data[AW-1:0];
            A_MDATA: begin
              mem_we    <= 1'b1;
              mem_waddr <= maddr;
              mem_wdata <= wr_data;
            end
            A_EV1: begin
              ev[0]   <= {wr_data[7:1], 1'b0};
              off_req <= wr_data[0];
            end
            A_EV2:   ev[1]  <= wr_data;
            A_EV3:   ev[2]  <= wr_data;
            A_CFGSH: cfg_sh <= wr_data;
            A_CFG1:  cfg_g1 <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      if (rd_addr >= A_PTR0 && rd_addr < A_PTR0 + 8'(NPTR))
        rd_data <= ptr[3'(rd_addr - A_PTR0)];
      case (rd_addr)
        A_MADDR: rd_data <= 8'(maddr);
        A_EV1:   rd_data <= ev[0];
        A_EV2:   rd_data <= ev[1];
        A_EV3:   rd_data <= ev[2];
        A_CFGSH: rd_data <= cfg_sh;
        A_CFG1:  rd_data <= cfg_g1;
        A_STAT:  rd_data <= {6'd0, unlocked, busy};
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    assign ptr_idx[g] = ptr[g][IDX_W-1:0];
  end

  assign lvl12   = ev[0][3] | ev[1][3];
  assign lvl3    = ev[2][3];
  assign warm_en = ev[0][4] | ev[1][4] | ev[2][4];
  assign chg_en  = cfg_g1[1];
endmodule

// File: rtl/pwr_seq_mem.sv
module pwr_seq_mem #(
  parameter int AW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       idle,
  input  logic                       sleep_req,
  input  logic                       wake12_in,
  input  logic                       wake3_in,
  input  logic                       chg_in,
  input  logic                       warm_in,
  input  logic                       off_req,
  input  logic [NPTR-1:0][IDX_W-1:0] ptr_idx,
  input  logic                       lvl12,
  input  logic                       lvl3,
  input  logic                       warm_en,
  input  logic                       chg_en,
  output logic                       go,
  output logic [IDX_W-1:0]           start_idx
);
  localparam logic [IDX_W-1:0] END_IDX = '1;

  logic prev12, prev3, prevchg;
  logic trig12, trig3, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev12  <= 1'b0;
      prev3   <= 1'b0;
      prevchg <= 1'b0;
    end else begin
      prev12  <= wake12_in;
      prev3   <= wake3_in;
      prevchg <= chg_in;
    end
  end

  assign trig12 = (lvl12 ? wake12_in : (wake12_in & ~prev12)) |
                  (chg_en & chg_in & ~prevchg);
  assign trig3  = lvl3 ? wake3_in : (wake3_in & ~prev3);

  always_comb begin
    hit       = 1'b1;
    start_idx = END_IDX;
    if (warm_in && warm_en)  start_idx = ptr_idx[PI_WARM];
    else if (off_req)        start_idx = ptr_idx[PI_OFF];
    else if (sleep_req)      start_idx = ptr_idx[PI_SLEEP];
    else if (trig12)         start_idx = ptr_idx[PI_W12];
    else if (trig3)          start_idx = ptr_idx[PI_W3];
    else                     hit = 1'b0;
  end

  assign go = idle && hit && (start_idx != END_IDX);
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int PRESCALE = 32,
  localparam int AW = IDX_W + 2,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [IDX_W-1:0] start_idx,
  output logic [AW-1:0]    mem_raddr,
  input  logic [7:0]       mem_rdata,
  output logic [15:0]      msg,
  output logic             msg_valid,
  output logic             busy
);
  localparam logic [IDX_W-1:0] END_IDX = '1;

  eng_state_t       st;
  logic [IDX_W-1:0] idx;
  logic [2:0]       ph;
  logic [7:0]       hi, lo, dly, nxt;
  logic [PW-1:0]    pre;

  assign mem_raddr = {idx, ph[1:0]};
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      ph        <= '0;
      hi        <= '0;
      lo        <= '0;
      dly       <= '0;
      nxt       <= '0;
      pre       <= '0;
      msg       <= '0;
      msg_valid <= 1'b0;
    end else begin
      msg_valid <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          idx <= start_idx;
          ph  <= '0;
          st  <= S_FETCH;
        end
        S_FETCH: begin
          ph <= ph + 3'd1;
          case (ph)
            3'd1: hi  <= mem_rdata;
            3'd2: lo  <= mem_rdata;
            3'd3: dly <= mem_rdata;
            3'd4: begin
              nxt <= mem_rdata;
              st  <= S_EMIT;
            end
            default: ;
          endcase
        end
        S_EMIT: begin
          msg       <= {hi, lo};
          msg_valid <= 1'b1;
          pre       <= '0;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (dly == 8'd0) begin
            if (nxt[IDX_W-1:0] == END_IDX) st <= S_IDLE;
            else begin
              idx <= nxt[IDX_W-1:0];
              ph  <= '0;
              st  <= S_FETCH;
            end
          end else if (pre == PW'(PRESCALE - 1)) begin
            pre <= '0;
            dly <= dly - 8'd1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int PRESCALE = 32,
  localparam int AW = IDX_W + 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        sleep_req,
  input  logic        wake12_in,
  input  logic        wake3_in,
  input  logic        chg_in,
  input  logic        warm_in,
  output logic [15:0] msg,
  output logic        msg_valid,
  output logic        busy
);
  logic                       unlocked;
  logic                       mem_we;
  logic [AW-1:0]              mem_waddr, mem_raddr;
  logic [7:0]                 mem_wdata, mem_rdata;
  logic                       off_req;
  logic [NPTR-1:0][IDX_W-1:0] ptr_idx;
  logic                       lvl12, lvl3, warm_en, chg_en;
  logic                       go;
  logic [IDX_W-1:0]           start_idx;

  pwr_seq_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .unlocked(unlocked),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .off_req(off_req), .ptr_idx(ptr_idx), .lvl12(lvl12), .lvl3(lvl3),
    .warm_en(warm_en), .chg_en(chg_en)
  );

  pwr_seq_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  pwr_seq_arb #(.IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .idle(!busy), .sleep_req(sleep_req),
    .wake12_in(wake12_in), .wake3_in(wake3_in), .chg_in(chg_in),
    .warm_in(warm_in), .off_req(off_req), .ptr_idx(ptr_idx),
    .lvl12(lvl12), .lvl3(lvl3), .warm_en(warm_en), .chg_en(chg_en),
    .go(go), .start_idx(start_idx)
  );

  pwr_seq_engine #(.IDX_W(IDX_W), .PRESCALE(PRESCALE)) u_eng (
    .clk(clk), .rst(rst), .go(go), .start_idx(start_idx),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .msg(msg),
    .msg_valid(msg_valid), .busy(busy)
  );
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_valid,
  input logic             busy,
  input logic             go,
  input logic             unlocked,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [IDX_W-1:0] sleep_ptr
);
  assert_locked_write_R1: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && wr_en && wr_addr == A_PTR0) |=> $stable(sleep_ptr));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);

  assert_strobe_in_run_R5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> busy);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);

  assert_start_needs_event_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));
endmodule

bind pwr_seq_top pwr_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .busy(busy), .go(go),
  .unlocked(unlocked), .wr_en(wr_en), .wr_addr(wr_addr),
  .sleep_ptr(ptr_idx[0])
);

// File: tb/test_pwr_seq_top.sv
`timescale 1ns/1ps
module test_pwr_seq_top;
  localparam int P = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0]  rd_data;
  logic        sleep_req = 1'b0, wake12_in = 1'b0, wake3_in = 1'b0;
  logic        chg_in = 1'b0, warm_in = 1'b0;
  logic [15:0] msg;
  logic        msg_valid, busy;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, last_strobe = 0, strobes = 0;
  bit done = 0;
  logic [15:0] exp_msg[$];
  int          exp_gap[$];

  always #10 clk = ~clk;

  pwr_seq_top #(.PRESCALE(P)) i_pwr_seq_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sleep_req(sleep_req),
    .wake12_in(wake12_in), .wake3_in(wake3_in), .chg_in(chg_in),
    .warm_in(warm_in), .msg(msg), .msg_valid(msg_valid), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected messages as strobes appear
  always @(negedge clk) begin
    cyc++;
    if (!rst && msg_valid) begin
      strobes++;
      if (exp_msg.size() == 0) begin
        check("R9 unexpected message", int'(msg), 0);
      end else begin
        automatic logic [15:0] em = exp_msg.pop_front();
        automatic int eg = exp_gap.pop_front();
        check("R4 message value", int'(msg), int'(em));
        if (eg >= 0) check("R6 strobe spacing", cyc - last_strobe, eg);
      end
      last_strobe = cyc;
    end
  end

  task automatic push(logic [15:0] m, int gap);
    exp_msg.push_back(m);
    exp_gap.push_back(gap);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic unlock();
    wr(8'h00, 8'hC0);
    wr(8'h00, 8'h0C);
  endtask

  task automatic load(int idx, logic [15:0] m, logic [7:0] dl, logic [7:0] nx);
    wr(8'h01, 8'(idx * 4));     wr(8'h02, m[15:8]);
    wr(8'h01, 8'(idx * 4 + 1)); wr(8'h02, m[7:0]);
    wr(8'h01, 8'(idx * 4 + 2)); wr(8'h02, dl);
    wr(8'h01, 8'(idx * 4 + 3)); wr(8'h02, nx);
  endtask

  task automatic wait_done(string req);
    while (exp_msg.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(req, int'(busy), 0);
  endtask

  task automatic expect_none(string req);
    automatic int n0 = strobes;
    repeat (60) @(negedge clk);
    check(req, strobes - n0, 0);
    check(req, int'(busy), 0);
  endtask

  task automatic pulse_sleep();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  task automatic push_script_a();
    push(16'h1234, -1);
    push(16'hABCD, 7);
    push(16'h5A5A, 7 + P);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R3 reset state
    for (int i = 0; i < 5; i++) begin
      rd(8'(3 + i), d); check("R3 pointer reset", d, 8'h3F);
    end
    rd(8'h0B, d); check("R3 shared transition reset", d, 8'h01);
    rd(8'h0C, d); check("R3 group1 transition reset", d, 8'h02);
    rd(8'h0D, d); check("R3 status reset", d, 8'h00);
    check("R3 busy reset", int'(busy), 0);

    // R1 locked writes ignored
    wr(8'h03, 8'h05);
    rd(8'h03, d); check("R1 locked write ignored", d, 8'h3F);
    unlock();
    rd(8'h0D, d); check("R2 unlocked status", d, 8'h02);
    wr(8'h03, 8'h05);
    rd(8'h03, d); check("R1 unlocked write taken", d, 8'h05);

    // R2 relock paths
    wr(8'h00, 8'h00);
    wr(8'h03, 8'h22);
    rd(8'h03, d); check("R2 zero relocks", d, 8'h05);
    wr(8'h00, 8'h0C); wr(8'h00, 8'hC0);
    wr(8'h03, 8'h22);
    rd(8'h03, d); check("R2 wrong key order", d, 8'h05);
    unlock(); wr(8'h00, 8'h55);
    wr(8'h03, 8'h22);
    rd(8'h03, d); check("R2 stray key relocks", d, 8'h05);
    rd(8'h0D, d); check("R2 locked status", d, 8'h00);

    // scripts
    unlock();
    load(0, 16'h1234, 8'd0, 8'd1);
    load(1, 16'hABCD, 8'd1, 8'd2);
    load(2, 16'h5A5A, 8'd0, 8'h3F);
    load(10, 16'hB001, 8'd0, 8'h3F);
    load(20, 16'hC003, 8'd0, 8'h3F);
    load(30, 16'hEE01, 8'd0, 8'h3F);
    load(40, 16'h0FF0, 8'd0, 8'h3F);
    wr(8'h03, 8'd0); wr(8'h04, 8'd10); wr(8'h05, 8'd20);
    wr(8'h06, 8'd30); wr(8'h07, 8'd40);

    // R4 R5 R6 linked walk with delays
    push_script_a();
    pulse_sleep();
    wait_done("R5 script ends at end index");

    // R9 wake3 edge during a running script is dropped
    push_script_a();
    pulse_sleep();
    repeat (5) @(negedge clk);
    wake3_in = 1'b1;
    wait_done("R9 script completes");
    expect_none("R9 event during run dropped");
    wake3_in = 1'b0;

    // R8 priority: warm beats sleep and wake12
    wr(8'h08, 8'h10);
    push(16'hEE01, -1);
    @(negedge clk);
    warm_in = 1'b1; sleep_req = 1'b1; wake12_in = 1'b1;
    @(negedge clk);
    warm_in = 1'b0; sleep_req = 1'b0;
    wait_done("R8 warm wins");
    expect_none("R8 losers dropped");
    wake12_in = 1'b0;
    // R8 sleep beats wake3
    push_script_a();
    @(negedge clk); sleep_req = 1'b1; wake3_in = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    wait_done("R8 sleep wins");
    expect_none("R8 wake3 dropped");
    wake3_in = 1'b0;

    // R11 warm without enable
    wr(8'h08, 8'h00);
    @(negedge clk); warm_in = 1'b1;
    @(negedge clk); warm_in = 1'b0;
    expect_none("R11 warm disabled");

    // R10 level-sensitive wake3 starts after running script
    wr(8'h0A, 8'h08);
    push_script_a();
    push(16'hC003, -1);
    pulse_sleep();
    repeat (5) @(negedge clk);
    wake3_in = 1'b1;
    wait (exp_msg.size() == 0);
    wake3_in = 1'b0;
    wait_done("R10 level wake runs");
    expect_none("R10 no extra run");
    wr(8'h0A, 8'h00);

    // R7 disabled pointer
    wr(8'h05, 8'h3F);
    @(negedge clk); wake3_in = 1'b1;
    repeat (2) @(negedge clk); wake3_in = 1'b0;
    expect_none("R7 disabled transition");

    // R12 device off by software
    push(16'h0FF0, -1);
    wr(8'h08, 8'h01);
    wait_done("R12 off script runs");
    rd(8'h08, d); check("R12 off bit reads 0", d, 8'h00);

    // R13 charger event
    push(16'hB001, -1);
    @(negedge clk); chg_in = 1'b1;
    repeat (2) @(negedge clk); chg_in = 1'b0;
    wait_done("R13 charger starts wake12");
    wr(8'h0C, 8'h00);
    rd(8'h0C, d); check("R13 charger bit cleared", d, 8'h00);
    @(negedge clk); chg_in = 1'b1;
    repeat (2) @(negedge clk); chg_in = 1'b0;
    expect_none("R13 charger ignored");

    check("R4 all expected messages seen", exp_msg.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule